// File: doc/BRIEF.md
# Endian-Aware Load/Store Byte Aligner

This unit sits between a processor datapath and a byte-addressable memory organised as 32-bit words. On a store it works out which byte lanes of the memory word to enable and moves the store operand into those lanes. On a load it takes the memory word, picks out the addressed byte, half-word or word, moves it to the bottom of the result and extends it to 32 bits. Each request carries its own byte-order bit, so big-endian and little-endian accesses can be mixed from cycle to cycle.

Half-word and word accesses must be aligned to their own size. A misaligned access raises an error flag, writes nothing and returns a zero load result. The unit registers its results, so every response appears exactly one clock after the request that caused it. The error flag is high only in that response cycle.

Top module: `aln_mem_aligner`

## Requirements
- R1: The size code is 2'b00 for a byte (1 byte), 2'b01 for a half-word (2 bytes) and 2'b10 for a word (4 bytes). Code 2'b11 is illegal: it raises `misalign_err`, enables no lanes and returns `ld_data` = 0.
- R2: Little-endian (`big_endian`=0): the memory byte at word offset o (o = `req_addr[1:0]`) is lane o, meaning bits 8o+7..8o of the memory word. The least significant byte of the operand goes to the lowest address. Example: a byte load at offset 0 of 0x11223344 returns 0x44.
- R3: Big-endian (`big_endian`=1): the memory byte at offset o is lane 3-o. The most significant byte of the operand goes to the lowest address. Example: a byte load at offset 0 of 0x11223344 returns 0x11.
- R4: A legal store of N bytes asserts exactly N contiguous `lane_we` bits, the lanes that hold offsets o..o+N-1. `wr_word` carries the operand's low N bytes in those lanes, ordered as R2/R3 require, and zero in every other lane.
- R5: A half-word at an odd offset, or a word at a nonzero offset, is misaligned. It raises `misalign_err`, leaves all `lane_we` low and returns `ld_data` = 0.
- R6: Byte and half-word loads are sign-extended to 32 bits when `ld_unsigned`=0 and zero-extended when it is 1. A word load returns the full word.
- R7: A load never asserts any `lane_we`. `wr_word` and `ld_data` are both 0 for any response that is not a legal store or a legal load, respectively.
- R8: Each response is registered and appears one cycle after `req_vld`, with `rsp_vld` high. In a cycle with no response, `lane_we`, `misalign_err` and `ld_data` are all 0, so the error flag is a single-cycle pulse.
- R9: During reset all outputs are 0.
- R10: The byte order is taken from each request. Back-to-back requests with opposite `big_endian` values each follow their own mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | Access size code (see R1) |
| big_endian | input | 1 | Byte order for this request |
| ld_unsigned | input | 1 | Zero-extend narrow loads |
| st_data | input | 32 | Store operand, right-justified |
| mem_rdata | input | 32 | Memory word read at the addressed word |
| rsp_vld | output | 1 | Response present this cycle |
| lane_we | output | 4 | Byte-lane write enables |
| wr_word | output | 32 | Store data placed in lanes |
| ld_data | output | 32 | Extracted and extended load result |
| misalign_err | output | 1 | Misaligned or illegal access |

## Verification
All four results (`lane_we`, `wr_word`, `ld_data` and `misalign_err`) are due in the first clock after the request's edge, and they must be zero in any cycle that has no request behind it. The driver stamps each expected item with the cycle it is due. The monitor samples on the falling clock edge and compares an item only in its stamped cycle. As a result, a response that arrives a cycle late or early, or a lingering error pulse, appears as a mismatch against the zero item expected for an idle cycle.

// File: rtl/aln_pkg.sv
package aln_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  // Bytes moved by an access of the given size; 0 marks an illegal code.
  function automatic int unsigned size_bytes(acc_size_e s, int unsigned word_bytes);
    case (s)
      SZ_BYTE: size_bytes = 1;
      SZ_HALF: size_bytes = 2;
      SZ_WORD: size_bytes = word_bytes;
      default: size_bytes = 0;
    endcase
  endfunction

  // Lowest lane an aligned access occupies.
  function automatic int unsigned low_lane(int unsigned ofs, int unsigned nb,
                                           bit be, int unsigned word_bytes);
    if (be) low_lane = word_bytes - ofs - nb;
    else    low_lane = ofs;
  endfunction
endpackage

// File: rtl/aln_align_chk.sv
module aln_align_chk
  import aln_pkg::*;
#(
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned OFS_W = $clog2(WORD_BYTES)
) (
  input  logic [OFS_W-1:0] ofs,
  input  logic [1:0]       size,
  output logic [OFS_W:0]   nbytes,
  output logic             misalign
);
  always_comb begin
    nbytes   = (OFS_W+1)'(size_bytes(acc_size_e'(size), WORD_BYTES));
    misalign = 1'b0;
    case (acc_size_e'(size))
      SZ_BYTE: misalign = 1'b0;
      SZ_HALF: misalign = ofs[0];
      SZ_WORD: misalign = |ofs;
      default: misalign = 1'b1;
    endcase
  end
endmodule

// File: rtl/aln_store_lanes.sv
module aln_store_lanes #(
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned OFS_W  = $clog2(WORD_BYTES),
  localparam int unsigned DATA_W = 8 * WORD_BYTES
) (
  input  logic              enable,
  input  logic [OFS_W:0]    shift,
  input  logic [OFS_W:0]    nbytes,
  input  logic [DATA_W-1:0] data,
  output logic [WORD_BYTES-1:0] we,
  output logic [DATA_W-1:0] word
);
  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_lane
    always_comb begin
      int idx;
      idx = k - int'(shift);
      we[k] = 1'b0;
      word[8*k +: 8] = 8'h00;
      if (enable && idx >= 0 && idx < int'(nbytes)) begin
        we[k] = 1'b1;
        word[8*k +: 8] = data[8*idx +: 8];
      end
    end
  end
endmodule

// File: rtl/aln_load_extract.sv
module aln_load_extract #(
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned OFS_W  = $clog2(WORD_BYTES),
  localparam int unsigned DATA_W = 8 * WORD_BYTES
) (
  input  logic              enable,
  input  logic              zero_ext,
  input  logic [OFS_W:0]    shift,
  input  logic [OFS_W:0]    nbytes,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] justified;
  logic              top_bit;

  always_comb begin
    justified = '0;
    top_bit   = 1'b0;
    for (int j = 0; j < int'(WORD_BYTES); j++) begin
      if (j + int'(shift) < int'(WORD_BYTES) && j < int'(nbytes)) begin
        justified[8*j +: 8] = rdata[8*(j + int'(shift)) +: 8];
        if (j == int'(nbytes) - 1) top_bit = rdata[8*(j + int'(shift)) + 7];
      end
    end
  end

  always_comb begin
    result = '0;
    if (enable) begin
      for (int j = 0; j < int'(WORD_BYTES); j++) begin
        if (j < int'(nbytes)) result[8*j +: 8] = justified[8*j +: 8];
        else                  result[8*j +: 8] = {8{top_bit & ~zero_ext}};
      end
    end
  end
endmodule

// File: rtl/aln_mem_aligner.sv
module aln_mem_aligner
  import aln_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned OFS_W  = $clog2(WORD_BYTES),
  localparam int unsigned DATA_W = 8 * WORD_BYTES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_vld,
  input  logic                  req_store,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [1:0]            req_size,
  input  logic                  big_endian,
  input  logic                  ld_unsigned,
  input  logic [DATA_W-1:0]     st_data,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic                  rsp_vld,
  output logic [WORD_BYTES-1:0] lane_we,
  output logic [DATA_W-1:0]     wr_word,
  output logic [DATA_W-1:0]     ld_data,
  output logic                  misalign_err
);
  logic [OFS_W-1:0] ofs;
  logic [OFS_W:0]   nbytes;
  logic [OFS_W:0]   shift;
  logic             bad_access;
  logic             store_go;
  logic             load_go;
  logic [WORD_BYTES-1:0] we_d;
  logic [DATA_W-1:0]     word_d;
  logic [DATA_W-1:0]     ld_d;
  logic                  unused_addr_hi;

  // Event wires for the checks below.
  logic             st_q;
  logic [OFS_W:0]   nbytes_q;

  assign ofs            = req_addr[OFS_W-1:0];
  assign unused_addr_hi = ^req_addr[ADDR_W-1:OFS_W];

  aln_align_chk #(.WORD_BYTES(WORD_BYTES)) u_chk (
    .ofs(ofs), .size(req_size), .nbytes(nbytes), .misalign(bad_access)
  );

  assign shift    = (OFS_W+1)'(low_lane(int'(ofs), int'(nbytes), big_endian, WORD_BYTES));
  assign store_go = req_vld &  req_store & ~bad_access;
  assign load_go  = req_vld & ~req_store & ~bad_access;

  aln_store_lanes #(.WORD_BYTES(WORD_BYTES)) u_st (
    .enable(store_go), .shift(shift), .nbytes(nbytes), .data(st_data),
    .we(we_d), .word(word_d)
  );

  aln_load_extract #(.WORD_BYTES(WORD_BYTES)) u_ld (
    .enable(load_go), .zero_ext(ld_unsigned), .shift(shift), .nbytes(nbytes),
    .rdata(mem_rdata), .result(ld_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld      <= 1'b0;
      lane_we      <= '0;
      wr_word      <= '0;
      ld_data      <= '0;
      misalign_err <= 1'b0;
      st_q         <= 1'b0;
      nbytes_q     <= '0;
    end else begin
      rsp_vld      <= req_vld;
      lane_we      <= we_d;
      wr_word      <= word_d;
      ld_data      <= ld_d;
      misalign_err <= req_vld & bad_access;
      st_q         <= req_vld & req_store;
      nbytes_q     <= nbytes;
    end
  end

  // R5: an error response writes nothing
  a_r5_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_err |-> (lane_we == '0 && ld_data == '0));

  // R4: a legal store enables exactly its size in lanes
  a_r4_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && st_q && !misalign_err) |-> ($countones(lane_we) == int'(nbytes_q)));

  // R7: loads never enable a lane
  a_r7_load_no_we: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && !st_q) |-> (lane_we == '0 && wr_word == '0));

  // R8: nothing moves without a response
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_vld |-> (lane_we == '0 && !misalign_err && ld_data == '0));

  // R8: a response follows a request by one cycle
  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld);
endmodule

// File: tb/aln_mem_aligner_bench.sv
`timescale 1ns/1ps
module aln_mem_aligner_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_vld = 1'b0, req_store = 1'b0, big_endian = 1'b0, ld_unsigned = 1'b0;
  logic [31:0] req_addr = '0, st_data = '0, mem_rdata = '0;
  logic [1:0]  req_size = '0;
  logic        rsp_vld, misalign_err;
  logic [3:0]  lane_we;
  logic [31:0] wr_word, ld_data;

  aln_mem_aligner u_aln_mem_aligner (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_store(req_store),
    .req_addr(req_addr), .req_size(req_size), .big_endian(big_endian),
    .ld_unsigned(ld_unsigned), .st_data(st_data), .mem_rdata(mem_rdata),
    .rsp_vld(rsp_vld), .lane_we(lane_we), .wr_word(wr_word),
    .ld_data(ld_data), .misalign_err(misalign_err)
  );

  typedef struct {
    int          due;
    logic        vld;
    logic [3:0]  we;
    logic [31:0] ww;
    logic [31:0] ld;
    logic        err;
    string       tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Expected result built offset by offset from the byte-order rules.
  function automatic exp_t model(bit vld, bit st, logic [31:0] a, logic [1:0] sz,
                                 bit be, bit uns, logic [31:0] sd, logic [31:0] rd);
    exp_t e;
    int n, o;
    e.vld = vld; e.we = '0; e.ww = '0; e.ld = '0; e.err = 1'b0;
    if (!vld) return e;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 0;
    o = int'(a[1:0]);
    if (n == 0 || (o % n) != 0) begin
      e.err = 1'b1;
      return e;
    end
    for (int j = 0; j < n; j++) begin
      int off, vb, lane;
      off  = o + j;
      vb   = be ? (n - 1 - j) : j;
      lane = be ? (3 - off) : off;
      if (st) begin
        e.we[lane] = 1'b1;
        e.ww[8*lane +: 8] = sd[8*vb +: 8];
      end else begin
        e.ld[8*vb +: 8] = rd[8*lane +: 8];
      end
    end
    if (!st && !uns && e.ld[8*n-1])
      for (int b = n; b < 4; b++) e.ld[8*b +: 8] = 8'hFF;
    return e;
  endfunction

  task automatic drive(bit vld, bit st, logic [31:0] a, logic [1:0] sz, bit be,
                       bit uns, logic [31:0] sd, logic [31:0] rd, string tag);
    exp_t e;
    @(negedge clk);
    req_vld = vld; req_store = st; req_addr = a; req_size = sz;
    big_endian = be; ld_unsigned = uns; st_data = sd; mem_rdata = rd;
    e = model(vld, st, a, sz, be, uns, sd, rd);
    e.due = cyc + 1;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(string tag);
    drive(1'b0, 1'b0, 32'h0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, tag);
  endtask

  // Monitor: compares each expected item in the cycle it is due.
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (rsp_vld !== e.vld || lane_we !== e.we || wr_word !== e.ww ||
          ld_data !== e.ld || misalign_err !== e.err) begin
        errors++;
        $display("FAIL %s: got vld=%b we=%b ww=%h ld=%h err=%b, expected vld=%b we=%b ww=%h ld=%h err=%b",
                 e.tag, rsp_vld, lane_we, wr_word, ld_data, misalign_err,
                 e.vld, e.we, e.ww, e.ld, e.err);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got running, expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R9 reset state
    if (rsp_vld !== 1'b0 || lane_we !== 4'h0 || wr_word !== 32'h0 ||
        ld_data !== 32'h0 || misalign_err !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset: got vld=%b we=%b ww=%h ld=%h err=%b, expected all zero",
               rsp_vld, lane_we, wr_word, ld_data, misalign_err);
    end
    rst_n = 1'b1;

    // R2 / R3: word at address 100 and byte at its first address
    drive(1, 1, 32'd100, 2'd2, 0, 0, 32'h11223344, 0, "R2 LE word store");
    drive(1, 1, 32'd100, 2'd2, 1, 0, 32'h11223344, 0, "R3 BE word store");
    drive(1, 0, 32'd100, 2'd0, 0, 1, 0, 32'h11223344, "R2 LE first byte 0x44");
    drive(1, 0, 32'd100, 2'd0, 1, 1, 0, 32'h11223344, "R3 BE first byte 0x11");
    // R4: narrow stores land in the right lanes
    drive(1, 1, 32'd101, 2'd0, 0, 0, 32'hFFFF_FFAB, 0, "R4 LE byte store off1");
    drive(1, 1, 32'd101, 2'd0, 1, 0, 32'hFFFF_FFAB, 0, "R4 BE byte store off1");
    drive(1, 1, 32'd102, 2'd1, 0, 0, 32'h1234_BEEF, 0, "R4 LE half store off2");
    drive(1, 1, 32'd102, 2'd1, 1, 0, 32'h1234_BEEF, 0, "R4 BE half store off2");
    // R5 misaligned, then an idle cycle to show the pulse ends (R8)
    drive(1, 1, 32'd101, 2'd1, 0, 0, 32'hBEEF, 0, "R5 odd half store");
    idle("R8 error pulse ends");
    drive(1, 1, 32'd102, 2'd2, 1, 0, 32'h55AA55AA, 0, "R5 word store off2");
    drive(1, 0, 32'd103, 2'd1, 0, 0, 0, 32'h8001_7F00, "R5 odd half load");
    // R1 illegal size code
    drive(1, 1, 32'd100, 2'd3, 0, 0, 32'h1, 0, "R1 reserved size store");
    drive(1, 0, 32'd100, 2'd3, 1, 0, 0, 32'hFFFF_FFFF, "R1 reserved size load");
    // R6 extension
    drive(1, 0, 32'd102, 2'd1, 0, 0, 0, 32'h8001_7F00, "R6 LE half signed");
    drive(1, 0, 32'd102, 2'd1, 0, 1, 0, 32'h8001_7F00, "R6 LE half unsigned");
    drive(1, 0, 32'd100, 2'd1, 1, 0, 0, 32'h8001_7F00, "R6 BE half signed");
    drive(1, 0, 32'd102, 2'd1, 1, 0, 0, 32'h8001_7F00, "R6 BE half positive");
    drive(1, 0, 32'd101, 2'd0, 0, 0, 0, 32'h0000_8000, "R6 byte signed");
    drive(1, 0, 32'd101, 2'd0, 0, 1, 0, 32'h0000_8000, "R6 byte unsigned");
    drive(1, 0, 32'd100, 2'd2, 0, 0, 0, 32'h8765_4321, "R6 word load");
    // R7 load with store data present writes nothing
    drive(1, 0, 32'd100, 2'd2, 0, 0, 32'hFFFF_FFFF, 32'h1, "R7 load no enables");
    idle("R8 idle");
    // R10 byte order flips every request
    for (int i = 0; i < 8; i++)
      drive(1, i[1], 32'd200 + 32'(i % 4), 2'd0, i[0], 0, 32'h0000_00C3 + 32'(i),
            32'hA1B2_C3D4, "R10 alternating order");

    // Sweep all codes, offsets, orders and directions (R1..R7)
    for (int sz = 0; sz < 4; sz++)
      for (int o = 0; o < 4; o++)
        for (int be = 0; be < 2; be++)
          for (int st = 0; st < 2; st++)
            for (int u = 0; u < 2; u++)
              drive(1, st[0], 32'h1000 + 32'(o), sz[1:0], be[0], u[0],
                    32'h9A7B_E5C1 ^ 32'(o * 32'h0101_0101),
                    32'hF08C_3A71 ^ 32'(sz * 32'h1357_0000), "R4 R6 sweep");

    idle("R8 tail");
    idle("R8 tail");
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule